// File: doc/BRIEF.md
# Ping-Pong Stream Bank Switch Sequencer

This block drives the two data-path switches that sit between an accelerator, the host-facing transfer logic and two pairs of external memory banks. Each side, X for input data and Y for results, has a two-way switch. With the select at 0 (straight) the host path reaches bank B and the accelerator reaches bank A. With the select at 1 (crossed) the host path reaches bank A and the accelerator reaches bank B.

The sequencer runs two alternating phases. In the first phase both selects are 0. The accelerator consumes AX and fills AY, while the host empties BY and refills BX. In the second phase both selects are 1 and the roles of the A and B banks are exchanged. A phase ends only after the accelerator and the host have each pulsed their done strobe, in any order. The `run` output then falls and a quiet gap starts. The switches flip partway through the gap, and `run` rises again once the gap has ended.

An override input hands each switch select directly to a control register and stops sequencing while it is held.

Top module: `pp_stream_switch_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets run to 0, phase to 0 (first phase), and sw_x and sw_y to 0 (straight).
- R2: In the idle state, a start pulse with override off sets run to 1 at the next edge, with phase 0 and both selects 0. A start pulse while run is 1 has no effect.
- R3: A phase ends only when both acc_done and host_done have been pulsed during the current run. They may come in either order, in the same cycle, or with any number of cycles between them. One strobe alone, even repeated, leaves run at 1 and phase unchanged.
- R4: Let E be the edge that samples the completing strobe. run is 0 from E onward. phase, sw_x and sw_y toggle at edge E+PRE_GAP. run returns to 1 at edge E+PRE_GAP+POST_GAP.
- R5: sw_x and sw_y never change while run is 1.
- R6: While run is 1, both selects equal phase. Phase 0 means straight (select 0) and phase 1 means crossed (select 1). Phases keep alternating for as long as completions arrive.
- R7: Done strobes that arrive while the block is idle or in the gap are ignored and do not count toward the next phase.
- R8: While ovr_en is 1, each edge loads sw_x from ovr_sel[0] and sw_y from ovr_sel[1]. The two selects are independent. run is forced to 0, phase to 0, and start is ignored.
- R9: One edge after ovr_en falls, both selects return to 0. A later start resumes at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin sequencing from the idle state |
| acc_done | input | 1 | Accelerator pass complete strobe |
| host_done | input | 1 | Host transfer complete strobe |
| ovr_en | input | 1 | Direct switch control, sequencing disabled |
| ovr_sel | input | 2 | Override selects: bit 0 X side, bit 1 Y side |
| sw_x | output | 1 | X-side switch select (0 straight, 1 crossed) |
| sw_y | output | 1 | Y-side switch select (0 straight, 1 crossed) |
| phase | output | 1 | 0 first phase, 1 second phase |
| run | output | 1 | Transfers may proceed |

## Verification
The bench builds the block with PRE_GAP=2 and POST_GAP=3. This keeps the gap short and asymmetric, so an off-by-one at either the switch edge or the resume edge shows up on a specific cycle. With this setting the bench sweeps four strobe orderings against zero to three cycles of separation across sixteen consecutive phases, and checks each gap cycle by cycle. All four override select combinations are also reached in a few cycles.

// File: rtl/pp_swap_pkg.sv
package pp_swap_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_RUN  = 2'd1,
    PS_GAP  = 2'd2
  } seq_state_e;

  localparam int SIDES = 2;

endpackage

// File: rtl/pp_done_tracker.sv
module pp_done_tracker (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic clear,
  input  logic acc_done,
  input  logic host_done,
  output logic both_done
);

  logic acc_seen_q;
  logic host_seen_q;

  assign both_done = arm && (acc_seen_q || acc_done) && (host_seen_q || host_done);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_seen_q  <= 1'b0;
      host_seen_q <= 1'b0;
    end else if (arm) begin
      if (acc_done)  acc_seen_q  <= 1'b1;
      if (host_done) host_seen_q <= 1'b1;
    end
  end

  // R3: an accepted strobe is remembered until the phase closes
  assert_acc_latched_R3: assert property (@(posedge clk) disable iff (rst)
    (arm && !clear && acc_done) |=> acc_seen_q);
  assert_host_latched_R3: assert property (@(posedge clk) disable iff (rst)
    (arm && !clear && host_done) |=> host_seen_q);
  // R7: nothing is recorded while disarmed
  assert_no_latch_unarmed_R7: assert property (@(posedge clk) disable iff (rst)
    (!arm && !acc_seen_q) |=> !acc_seen_q);

endmodule

// File: rtl/pp_gap_timer.sv
module pp_gap_timer #(
  parameter int PRE_GAP  = 2,
  parameter int POST_GAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic abort,
  output logic swap_now,
  output logic resume,
  output logic busy
);

  localparam int TOTAL = PRE_GAP + POST_GAP;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy     = busy_q;
  assign swap_now = busy_q && (cnt_q == CNT_W'(PRE_GAP - 1));
  assign resume   = busy_q && (cnt_q == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (resume) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: switching and resuming never coincide, so a quiet cycle follows the swap
  assert_swap_before_resume_R4: assert property (@(posedge clk) disable iff (rst)
    swap_now |-> (busy_q && !resume));
  assert_resume_ends_gap_R4: assert property (@(posedge clk) disable iff (rst || abort)
    (resume && !go) |=> !busy_q);

endmodule

// File: rtl/pp_side_switch.sv
module pp_side_switch (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic val,
  output logic sel
);

  always_ff @(posedge clk) begin
    if (rst)       sel <= 1'b0;
    else if (load) sel <= val;
  end

endmodule

// File: rtl/pp_stream_switch_ctrl.sv
module pp_stream_switch_ctrl #(
  parameter int PRE_GAP  = 2,
  parameter int POST_GAP = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       acc_done,
  input  logic       host_done,
  input  logic       ovr_en,
  input  logic [1:0] ovr_sel,
  output logic       sw_x,
  output logic       sw_y,
  output logic       phase,
  output logic       run
);
  import pp_swap_pkg::*;

  seq_state_e       state_q;
  logic             run_q;
  logic             phase_q;
  logic [SIDES-1:0] sel_q;
  logic [SIDES-1:0] sel_load;
  logic [SIDES-1:0] sel_val;
  logic             both_done;
  logic             swap_now;
  logic             resume;
  logic             gap_busy;
  logic             arm;
  logic             close_phase;

  assign arm         = (state_q == PS_RUN) && !ovr_en;
  assign close_phase = arm && both_done;

  pp_done_tracker u_track (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .clear     (close_phase || ovr_en),
    .acc_done  (acc_done),
    .host_done (host_done),
    .both_done (both_done)
  );

  pp_gap_timer #(
    .PRE_GAP  (PRE_GAP),
    .POST_GAP (POST_GAP)
  ) u_gap (
    .clk      (clk),
    .rst      (rst),
    .go       (close_phase),
    .abort    (ovr_en),
    .swap_now (swap_now),
    .resume   (resume),
    .busy     (gap_busy)
  );

  for (genvar i = 0; i < SIDES; i++) begin : g_side
    always_comb begin
      sel_load[i] = 1'b0;
      sel_val[i]  = 1'b0;
      if (ovr_en) begin
        sel_load[i] = 1'b1;
        sel_val[i]  = ovr_sel[i];
      end else if (state_q == PS_IDLE) begin
        sel_load[i] = 1'b1;
        sel_val[i]  = 1'b0;
      end else if (state_q == PS_GAP && swap_now) begin
        sel_load[i] = 1'b1;
        sel_val[i]  = ~phase_q;
      end
    end

    pp_side_switch u_sw (
      .clk  (clk),
      .rst  (rst),
      .load (sel_load[i]),
      .val  (sel_val[i]),
      .sel  (sel_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || ovr_en) begin
      state_q <= PS_IDLE;
      run_q   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      case (state_q)
        PS_IDLE: begin
          phase_q <= 1'b0;
          if (start && (sel_q == '0)) begin
            state_q <= PS_RUN;
            run_q   <= 1'b1;
          end
        end
        PS_RUN: begin
          if (both_done) begin
            state_q <= PS_GAP;
            run_q   <= 1'b0;
          end
        end
        PS_GAP: begin
          if (swap_now) phase_q <= ~phase_q;
          if (resume) begin
            state_q <= PS_RUN;
            run_q   <= 1'b1;
          end
        end
        default: begin
          state_q <= PS_IDLE;
          run_q   <= 1'b0;
        end
      endcase
    end
  end

  assign sw_x  = sel_q[0];
  assign sw_y  = sel_q[1];
  assign phase = phase_q;
  assign run   = run_q;

  // R5: switches hold while transfers may be active
  assert_hold_sel_in_run_R5: assert property (@(posedge clk) disable iff (rst)
    run_q |-> $stable(sel_q));
  // R6: both switches agree with the phase during a run
  assert_sel_matches_phase_R6: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (sel_q[0] == phase_q && sel_q[1] == phase_q));
  // R4: completion stops transfers on the next cycle
  assert_stop_on_done_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && both_done && !ovr_en) |=> !run_q);
  // R4: gap timer runs exactly while sequencing is paused between phases
  assert_gap_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    gap_busy |-> !run_q);
  // R8: override loads the register value and halts sequencing
  assert_override_R8: assert property (@(posedge clk) disable iff (rst)
    ovr_en |=> (!run_q && !phase_q && sel_q == $past(ovr_sel)));

endmodule

// File: tb/test_pp_stream_switch_ctrl.sv
`timescale 1ns/1ps
module test_pp_stream_switch_ctrl;

  localparam int PRE  = 2;
  localparam int POST = 3;

  logic       clk = 1'b0;
  logic       rst, start, acc_done, host_done, ovr_en;
  logic [1:0] ovr_sel;
  logic       sw_x, sw_y, phase, run;

  int n_cmp = 0;
  int n_bad = 0;
  int ep    = 0;

  always #2.5 clk = ~clk;

  pp_stream_switch_ctrl #(.PRE_GAP(PRE), .POST_GAP(POST)) i_pp_stream_switch_ctrl (
    .clk(clk), .rst(rst), .start(start), .acc_done(acc_done), .host_done(host_done),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .sw_x(sw_x), .sw_y(sw_y), .phase(phase), .run(run)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int er, input int esel);
    check({tag, " run"},   int'(run),   er);
    check({tag, " phase"}, int'(phase), esel);
    check({tag, " sw_x"},  int'(sw_x),  esel);
    check({tag, " sw_y"},  int'(sw_y),  esel);
  endtask

  task automatic pulse(input logic a, input logic h);
    acc_done  = a;
    host_done = h;
    @(negedge clk);
    acc_done  = 1'b0;
    host_done = 1'b0;
  endtask

  // called right after the completing strobe's edge; R4 gap timing, R5 hold
  task automatic finish_phase(input bit inject);
    for (int t = 0; t <= PRE + POST; t++) begin
      chk_state("R4", (t == PRE + POST) ? 1 : 0, (t >= PRE) ? 1 - ep : ep);
      if (t < PRE + POST) begin
        if (inject && t == 1) begin acc_done = 1'b1; host_done = 1'b1; end
        if (inject && t == 2) begin acc_done = 1'b0; host_done = 1'b0; end
        @(negedge clk);
      end
    end
    ep = 1 - ep;
  endtask

  // order 0 acc first, 1 host first, 2 together, 3 acc twice then host
  task automatic run_phase(input int order, input int d, input bit inject);
    chk_state("R6", 1, ep);
    if (order == 2) begin
      pulse(1'b1, 1'b1);
    end else begin
      if (order == 1) pulse(1'b0, 1'b1);
      else            pulse(1'b1, 1'b0);
      if (order == 3) pulse(1'b1, 1'b0);
      chk_state("R3", 1, ep);
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        chk_state("R3", 1, ep);
      end
      if (order == 1) pulse(1'b1, 1'b0);
      else            pulse(1'b0, 1'b1);
    end
    finish_phase(inject);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; acc_done = 1'b0; host_done = 1'b0;
    ovr_en = 1'b0; ovr_sel = 2'b00;
    repeat (3) @(negedge clk);
    chk_state("R1", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_state("R1", 0, 0);

    // R7: strobes while idle are not counted
    pulse(1'b1, 1'b1);
    chk_state("R7", 0, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk_state("R2", 1, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk_state("R7", 1, 0);
    end

    // R3/R4/R6 sweep: every ordering against several separations
    for (int o = 0; o < 4; o++)
      for (int d = 0; d < 4; d++)
        run_phase(o, d, 1'b0);

    // R7: strobes in the gap are ignored
    run_phase(2, 0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk_state("R7", 1, ep);
    end
    run_phase(0, 1, 1'b0);

    // R2: start while running changes nothing
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk_state("R2", 1, ep);
    @(negedge clk);
    chk_state("R2", 1, ep);

    // R8: override sweep, start ignored
    ovr_en = 1'b1;
    for (int v = 0; v < 4; v++) begin
      ovr_sel = 2'(v);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R8 sw_x", int'(sw_x), v & 1);
      check("R8 sw_y", int'(sw_y), (v >> 1) & 1);
      check("R8 run", int'(run), 0);
      check("R8 phase", int'(phase), 0);
      @(negedge clk);
      check("R8 hold sw_x", int'(sw_x), v & 1);
      check("R8 hold sw_y", int'(sw_y), (v >> 1) & 1);
    end
    ovr_sel = 2'b11;
    @(negedge clk);
    ovr_en = 1'b0;
    @(negedge clk);
    chk_state("R9", 0, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    ep = 0;
    chk_state("R9", 1, 0);
    run_phase(1, 2, 1'b0);
    run_phase(0, 0, 1'b0);

    // R1: reset during a run
    rst = 1'b1;
    @(negedge clk);
    chk_state("R1", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_state("R1", 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule